// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Staged Write Hits

This block sits between a 32-bit processor load/store port and a memory port that moves whole 128-bit lines. It holds a number of lines set by a parameter. Each line has four 32-bit words, one tag, one valid flag and one dirty flag. Each address has exactly one line it may occupy, so the block needs no placement choice and no replacement policy. A read that hits returns its word one cycle after it is accepted.

A write that hits is split over two cycles. In the accept cycle the tag is compared and the address, data and byte mask are captured in registers. The next cycle is the commit cycle. In it, only those registered values drive the write of the selected word, and the line is marked dirty. The block takes no request during the commit cycle.

A miss blocks the port. If the victim line is valid and dirty, it is first written back to memory as one line. The missing line is then fetched and installed, and the original request is run again against the new line.

The processor side is a valid/ready request channel. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. The requester holds its fields stable while `req_valid` is high and `req_ready` is low. The response channel has no back-pressure: `rsp_valid` is a single-cycle pulse. The memory request channel is also valid/ready, and the cache holds it stable until `mem_req_ready` is seen. The memory read response is a single-cycle `mem_rsp_valid` pulse with no back-pressure.

Top module: `dm_cache`

## Requirements
- R1: An address splits into fields: bits [1:0] are a byte offset that is ignored, bits [3:2] pick the word in the line, bits [IDX_W+3:4] pick the line, and the bits above form the tag. The memory line address is addr[ADDR_W-1:4].
- R2: A read hit raises `rsp_valid` in the cycle after acceptance, and `rsp_rdata` carries the stored word. `req_ready` stays high, so back-to-back reads are accepted.
- R3: A write hit is followed by one commit cycle. In that cycle `req_ready` is low and `rsp_valid` is low. `rsp_valid` pulses in the cycle after the commit, and `req_ready` is high again in that same cycle.
- R4: Bit `req_be[i]` enables bits [8i+7:8i] of the word. Bytes whose enable bit is clear keep their old value.
- R5: A read of a word returns the last value committed to it, whether the line stayed resident or went through a write-back and a refill.
- R6: After reset, every line is invalid and not dirty, `req_ready` is high, and `rsp_valid` and `mem_req_valid` are low. The first access to any line is a miss.
- R7: On a miss, exactly one memory read of the request's line address is issued. The returned line is installed as valid and clean, and the request is then completed as a hit.
- R8: On a miss whose victim is valid and dirty, exactly one memory write is issued before the read. It carries the victim's line address ({old tag, index}) and its current contents. A clean victim causes no write.
- R9: On the memory port, word w of a line is carried in bits [32w+31:32w].
- R10: `req_ready` is low from the accepting edge of a miss until `rsp_valid` for that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for a write |
| rsp_valid | output | 1 | Response pulse (read data or write done) |
| rsp_rdata | output | 32 | Read data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = line write-back, 0 = line fetch |
| mem_req_addr | output | ADDR_W-4 | Line address |
| mem_req_wdata | output | 128 | Write-back line |
| mem_rsp_valid | input | 1 | Fetched line present |
| mem_rsp_rdata | input | 128 | Fetched line |

## Verification
The first pattern is a sequential read sweep over four times the cache size. It separates the first-word miss of each line from the three hits that follow, and it evicts clean lines, so any write to memory points to a wrong dirty flag. The second pattern is a scatter of writes, each followed by a read of the same word, with every byte-enable value used. It separates merge errors in individual byte lanes and shows the two-cycle write timing. The third pattern is a conflict sweep that writes eight tags into each index in turn. Each step evicts a dirty line, which tests the write-back address, the write-back data and the ordering of write-back before fetch. A final full read-back, with nonzero byte offsets mixed in, compares every word against a flat reference memory.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  localparam int WORD_W  = 32;
  localparam int WPL     = 4;
  localparam int LINE_W  = WORD_W * WPL;
  localparam int BYTES   = WORD_W / 8;
  localparam int BOFF_W  = $clog2(BYTES);
  localparam int WSEL_W  = $clog2(WPL);
  localparam int OFF_W   = BOFF_W + WSEL_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COMMIT,
    ST_EVICT,
    ST_FILL,
    ST_WAIT,
    ST_REPLAY
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             fill_we,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             dirty_we,
  input  logic [IDX_W-1:0] dirty_idx
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_we) begin
      valid_q[fill_idx] <= 1'b1;
      dirty_q[fill_idx] <= 1'b0;
    end else if (dirty_we) begin
      dirty_q[dirty_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_we) tag_q[fill_idx] <= fill_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];

  // R6: leaving reset leaves every line empty
  a_r6_empty_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (valid_q == '0 && dirty_q == '0));

  // R7: an installed line is valid and clean
  a_r7_fill_valid_clean: assert property (@(posedge clk) disable iff (rst)
    fill_we |=> (valid_q[$past(fill_idx)] && !dirty_q[$past(fill_idx)]));
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store
  import dmc_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line,
  input  logic              ww_en,
  input  logic [IDX_W-1:0]  ww_idx,
  input  logic [WSEL_W-1:0] ww_word,
  input  logic [WORD_W-1:0] ww_data,
  input  logic [BYTES-1:0]  ww_be,
  input  logic              lw_en,
  input  logic [IDX_W-1:0]  lw_idx,
  input  logic [LINE_W-1:0] lw_data
);
  localparam int LINES = 1 << IDX_W;

  logic [LINE_W-1:0] line_q [LINES];
  logic [LINE_W-1:0] tgt_line;
  logic [WORD_W-1:0] old_w;
  logic [WORD_W-1:0] new_w;

  assign tgt_line = line_q[ww_idx];
  assign old_w    = tgt_line[int'(ww_word)*WORD_W +: WORD_W];

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign new_w[b*8 +: 8] = ww_be[b] ? ww_data[b*8 +: 8] : old_w[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (lw_en)
      line_q[lw_idx] <= lw_data;
    else if (ww_en)
      line_q[ww_idx][int'(ww_word)*WORD_W +: WORD_W] <= new_w;
  end

  assign rd_line = line_q[rd_idx];

  // R7: a refill and a staged word write never collide
  a_r7_single_writer: assert property (@(posedge clk) disable iff (rst)
    !(lw_en && ww_en));
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 25
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [WORD_W-1:0]       req_wdata,
  input  logic [BYTES-1:0]        req_be,
  output logic                    rsp_valid,
  output logic [WORD_W-1:0]       rsp_rdata,
  output logic [IDX_W-1:0]        look_idx,
  input  logic                    look_valid,
  input  logic                    look_dirty,
  input  logic [TAG_W-1:0]        look_tag,
  input  logic [LINE_W-1:0]       look_line,
  output logic                    ww_en,
  output logic [IDX_W-1:0]        ww_idx,
  output logic [WSEL_W-1:0]       ww_word,
  output logic [WORD_W-1:0]       ww_data,
  output logic [BYTES-1:0]        ww_be,
  output logic                    lw_en,
  output logic [TAG_W-1:0]        fill_tag,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic                    mem_req_write,
  output logic [ADDR_W-OFF_W-1:0] mem_req_addr,
  output logic [LINE_W-1:0]       mem_req_wdata,
  input  logic                    mem_rsp_valid
);
  dmc_state_e state_q, state_d;

  logic [ADDR_W-1:0] a_q;
  logic [WORD_W-1:0] d_q;
  logic [BYTES-1:0]  be_q;
  logic              w_q;
  logic              rsp_valid_q;
  logic [WORD_W-1:0] rsp_rdata_q;

  logic              in_idle;
  logic              lookup;
  logic [ADDR_W-1:0] la;
  logic              lw;
  logic [TAG_W-1:0]  l_tag;
  logic [WSEL_W-1:0] l_word;
  logic              hit;

  assign in_idle = (state_q == ST_IDLE);
  assign lookup  = in_idle ? req_valid : (state_q == ST_REPLAY);
  assign la      = in_idle ? req_addr  : a_q;
  assign lw      = in_idle ? req_write : w_q;
  assign look_idx = la[OFF_W +: IDX_W];
  assign l_tag    = la[ADDR_W-1 -: TAG_W];
  assign l_word   = la[BOFF_W +: WSEL_W];
  assign hit      = look_valid && (look_tag == l_tag);
  assign req_ready = in_idle;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:
        if (req_valid) begin
          if (hit)       state_d = req_write ? ST_COMMIT : ST_IDLE;
          else if (look_valid && look_dirty) state_d = ST_EVICT;
          else           state_d = ST_FILL;
        end
      ST_REPLAY: state_d = w_q ? ST_COMMIT : ST_IDLE;
      ST_COMMIT: state_d = ST_IDLE;
      ST_EVICT:  if (mem_req_ready) state_d = ST_FILL;
      ST_FILL:   if (mem_req_ready) state_d = ST_WAIT;
      ST_WAIT:   if (mem_rsp_valid) state_d = ST_REPLAY;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      a_q         <= '0;
      d_q         <= '0;
      be_q        <= '0;
      w_q         <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= (lookup && hit && !lw) || (state_q == ST_COMMIT);
      if (lookup && hit && !lw)
        rsp_rdata_q <= look_line[int'(l_word)*WORD_W +: WORD_W];
      if (in_idle && req_valid) begin
        a_q  <= req_addr;
        d_q  <= req_wdata;
        be_q <= req_be;
        w_q  <= req_write;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  // commit uses only the registered request
  assign ww_en   = (state_q == ST_COMMIT);
  assign ww_idx  = a_q[OFF_W +: IDX_W];
  assign ww_word = a_q[BOFF_W +: WSEL_W];
  assign ww_data = d_q;
  assign ww_be   = be_q;

  assign lw_en    = (state_q == ST_WAIT) && mem_rsp_valid;
  assign fill_tag = a_q[ADDR_W-1 -: TAG_W];

  assign mem_req_valid = (state_q == ST_EVICT) || (state_q == ST_FILL);
  assign mem_req_write = (state_q == ST_EVICT);
  assign mem_req_addr  = (state_q == ST_EVICT) ? {look_tag, a_q[OFF_W +: IDX_W]}
                                               : a_q[ADDR_W-1:OFF_W];
  assign mem_req_wdata = look_line;

  // R3: a word write happens only right after a write lookup that hit
  a_r3_commit_after_hit: assert property (@(posedge clk) disable iff (rst)
    ww_en |-> $past(lookup && hit && lw));

  // R10: a miss blocks the request port on the next cycle
  a_r10_block_on_miss: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !hit) |=> !req_ready);

  // R8: a write-back is issued only for a valid, dirty victim
  a_r8_writeback_dirty: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_write) |-> (look_valid && look_dirty));
endmodule

// File: rtl/dm_cache.sv
module dm_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [WORD_W-1:0]       req_wdata,
  input  logic [BYTES-1:0]        req_be,
  output logic                    rsp_valid,
  output logic [WORD_W-1:0]       rsp_rdata,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic                    mem_req_write,
  output logic [ADDR_W-OFF_W-1:0] mem_req_addr,
  output logic [LINE_W-1:0]       mem_req_wdata,
  input  logic                    mem_rsp_valid,
  input  logic [LINE_W-1:0]       mem_rsp_rdata
);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [IDX_W-1:0]  look_idx;
  logic              look_valid, look_dirty;
  logic [TAG_W-1:0]  look_tag;
  logic [LINE_W-1:0] look_line;
  logic              ww_en, lw_en;
  logic [IDX_W-1:0]  ww_idx;
  logic [WSEL_W-1:0] ww_word;
  logic [WORD_W-1:0] ww_data;
  logic [BYTES-1:0]  ww_be;
  logic [TAG_W-1:0]  fill_tag;

  dmc_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .look_idx(look_idx), .look_valid(look_valid), .look_dirty(look_dirty),
    .look_tag(look_tag), .look_line(look_line),
    .ww_en(ww_en), .ww_idx(ww_idx), .ww_word(ww_word), .ww_data(ww_data),
    .ww_be(ww_be), .lw_en(lw_en), .fill_tag(fill_tag),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid)
  );

  dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst),
    .rd_idx(look_idx), .rd_valid(look_valid), .rd_dirty(look_dirty),
    .rd_tag(look_tag),
    .fill_we(lw_en), .fill_idx(look_idx), .fill_tag(fill_tag),
    .dirty_we(ww_en), .dirty_idx(ww_idx)
  );

  dmc_data_store #(.IDX_W(IDX_W)) u_data (
    .clk(clk), .rst(rst),
    .rd_idx(look_idx), .rd_line(look_line),
    .ww_en(ww_en), .ww_idx(ww_idx), .ww_word(ww_word), .ww_data(ww_data),
    .ww_be(ww_be),
    .lw_en(lw_en), .lw_idx(look_idx), .lw_data(mem_rsp_rdata)
  );
endmodule

// File: tb/sim_dm_cache.sv
module sim_dm_cache;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 3;
  localparam int LINES  = 1 << IDX_W;
  localparam int MLINES = 64;
  localparam int MWORDS = MLINES * 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic mem_req_valid, mem_req_ready, mem_req_write;
  logic [ADDR_W-5:0] mem_req_addr;
  logic [127:0] mem_req_wdata;
  logic mem_rsp_valid;
  logic [127:0] mem_rsp_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  dm_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata)
  );

  function automatic logic [31:0] pat(int k);
    return (k * 32'h0000_9E37) ^ 32'hC0DE_0000;
  endfunction

  logic [31:0]  ref_mem [MWORDS];
  logic [127:0] bmem [MLINES];
  int n_chk = 0, n_fail = 0;
  int wb_chk = 0, wb_fail = 0;
  int rd_cnt = 0, wb_cnt = 0;
  int last_rd = 0, last_wb = 0;
  int pend = 0;
  logic [5:0] pline = '0;
  bit finished = 0;

  // behavioural line memory; R9 word w in bits [32w+31:32w]
  always @(posedge clk) begin
    if (rst) begin
      mem_req_ready <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_rdata <= '0;
      pend <= 0;
    end else begin
      mem_req_ready <= ~mem_req_ready;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          wb_cnt <= wb_cnt + 1;
          last_wb <= int'(mem_req_addr);
          for (int w = 0; w < 4; w++) begin
            wb_chk <= wb_chk + 1;
            if (mem_req_wdata[32*w +: 32] !== ref_mem[int'(mem_req_addr[5:0])*4 + w]) begin
              wb_fail <= wb_fail + 1;
              $display("FAIL R8 write-back line %0d word %0d act %h exp %h",
                       mem_req_addr, w, mem_req_wdata[32*w +: 32],
                       ref_mem[int'(mem_req_addr[5:0])*4 + w]);
            end
          end
          bmem[mem_req_addr[5:0]] <= mem_req_wdata;
        end else begin
          rd_cnt <= rd_cnt + 1;
          last_rd <= int'(mem_req_addr);
          pline <= mem_req_addr[5:0];
          pend <= 3;
        end
      end else if (pend != 0) begin
        pend <= pend - 1;
        if (pend == 1) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_rdata <= bmem[pline];
        end
      end
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  bit bv [LINES];
  bit bd [LINES];
  int bt [LINES];

  task automatic access(bit wr, int addr, logic [31:0] data, logic [3:0] be);
    int idx = (addr >> 4) % LINES;
    int tag = addr >> (4 + IDX_W);
    int k = (addr >> 2) % MWORDS;
    bit hit = bv[idx] && (bt[idx] == tag);
    bit dty = bv[idx] && bd[idx];
    int oldtag = bt[idx];
    int r0 = rd_cnt, w0 = wb_cnt;
    int lat = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr;
    req_wdata = data; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (hit && !wr) begin
      chk(rsp_valid === 1'b1, "R2 read-hit response next cycle", {31'd0, rsp_valid}, 32'd1);
      chk(req_ready === 1'b1, "R2 ready during read hit", {31'd0, req_ready}, 32'd1);
    end else if (hit && wr) begin
      chk(req_ready === 1'b0 && rsp_valid === 1'b0, "R3 commit cycle stalls",
          {30'd0, req_ready, rsp_valid}, 32'd0);
      @(negedge clk);
      chk(rsp_valid === 1'b1 && req_ready === 1'b1, "R3 write done after commit",
          {30'd0, req_ready, rsp_valid}, 32'd3);
    end else begin
      while (!rsp_valid && lat < 200) begin
        chk(req_ready === 1'b0, "R10 blocked while miss pending", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
        lat++;
      end
      chk(rsp_valid === 1'b1, "R7 miss completes", {31'd0, rsp_valid}, 32'd1);
      chk(last_rd == (addr >> 4), "R1 fetch line address", last_rd, addr >> 4);
      if (dty) chk(last_wb == (oldtag << IDX_W) + idx, "R8 victim line address",
                   last_wb, (oldtag << IDX_W) + idx);
    end
    chk(rd_cnt == r0 + (hit ? 0 : 1), "R7 fetch count", rd_cnt, r0 + (hit ? 0 : 1));
    chk(wb_cnt == w0 + ((!hit && dty) ? 1 : 0), "R8 write-back count",
        wb_cnt, w0 + ((!hit && dty) ? 1 : 0));
    if (!wr) begin
      chk(rsp_rdata === ref_mem[k], "R5 read data vs reference", rsp_rdata, ref_mem[k]);
    end else begin
      for (int b = 0; b < 4; b++)
        if (be[b]) ref_mem[k][8*b +: 8] = data[8*b +: 8];
    end
    if (!hit) begin bv[idx] = 1; bt[idx] = tag; bd[idx] = 0; end
    if (wr) bd[idx] = 1;
  endtask

  initial begin
    for (int k = 0; k < MWORDS; k++) ref_mem[k] = pat(k);
    for (int l = 0; l < MLINES; l++)
      for (int w = 0; w < 4; w++) bmem[l][32*w +: 32] = pat(l*4 + w);
    for (int i = 0; i < LINES; i++) begin bv[i] = 0; bd[i] = 0; bt[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b1, "R6 ready after reset", {31'd0, req_ready}, 32'd1);
    chk(rsp_valid === 1'b0, "R6 no response after reset", {31'd0, rsp_valid}, 32'd0);
    chk(mem_req_valid === 1'b0, "R6 no memory request after reset", {31'd0, mem_req_valid}, 32'd0);
    // first access must miss (R6), bench model holds all lines invalid
    access(0, 0, 0, 0);
    chk(rd_cnt == 1, "R6 first access misses", rd_cnt, 1);
    // sequential read sweep, clean evictions
    for (int a = 0; a < 512; a += 4) access(0, a, 0, 0);
    // scattered writes with every byte-enable value, each read back (R4)
    for (int i = 0; i < 64; i++) begin
      int a = (i * 52) % 1024;
      access(1, a, 32'hA5000000 ^ (i * 32'h01010101), i[3:0]);
      access(0, a, 0, 0);
    end
    // conflict sweep: eight tags per index, dirty victims
    for (int i = 0; i < LINES; i++)
      for (int t = 0; t < 8; t++)
        access(1, (t << 7) | (i << 4) | ((t & 3) << 2), 32'h5EED0000 + t*16 + i, 4'hF);
    // full read-back, nonzero byte offsets mixed in (R1)
    for (int a = 0; a < 1024; a += 4) access(0, a | ((a >> 4) & 3), 0, 0);
    finished = 1;
    n_chk += wb_chk;
    n_fail += wb_fail;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk += wb_chk + 1;
      n_fail += wb_fail + 1;
      $display("FAIL watchdog expired act 0 exp 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule